// File: doc/BRIEF.md
# Bus Snoop Coherency Controller

This block keeps a small single-ported data cache consistent with other bus masters, such as DMA engines, that read and write memory the cache may also hold. Each coherent bus request (read, write or invalidate) is looked up in the tag array. A read that hits returns the cached word. A write that hits overwrites the cached word. An invalidate that hits drops the line. A request that misses changes nothing. The core uses the same array port for loads, stores and line installs.

Each line carries a shared flag. The flag is set when a bus master reads the line out of this cache, or when the core installs a line that another caching master also holds. A core store that hits a shared line writes the word, sends the line's address out as an invalidate broadcast, and clears the flag. Store misses do not allocate a line.

The array has one port, so a single access is granted per cycle. Snoops normally win. A starvation guard hands the slot to a waiting core after a run of consecutive snoop grants. Both requesters use a request/grant handshake. Each result is registered and appears, with a one-cycle done strobe, in the cycle after the grant.

Top module: `snoopCoherency`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `snpDone`, `coreDone` and `invValid` are 0. Reset invalidates every line, so any later lookup misses until the line is installed again.
- R2: A snoop read (`snpOp`=0) that hits gives `snpDone`=1, `snpHit`=1 and `snpRdata` equal to the cached word, in the cycle after `snpGnt`.
- R3: A snoop write (`snpOp`=1) that hits replaces the addressed cached word with `snpWdata`. A later core load returns the new value.
- R4: A snoop read, write or invalidate (`snpOp`=2) that misses reports `snpHit`=0 and leaves every line's valid bit, tag and data unchanged.
- R5: A snoop read that hits marks the line shared.
- R6: A core install (`coreOp`=2) writes the word, makes the line valid with the new tag, and sets the shared flag to `coreFillShared`.
- R7: A core store (`coreOp`=1) that hits a shared line writes the word. In the next cycle it raises `invValid` for one cycle, with `invAddr` equal to the line address and bits [4:0] zero. It then clears the shared flag, so a second store to the line broadcasts nothing.
- R8: A core store that misses reports `coreHit`=0, writes nothing and broadcasts nothing. A core load (`coreOp`=0) that hits returns the cached word.
- R9: A snoop invalidate that hits clears the line's valid bit, so later lookups of that line miss.
- R10: At most one of `snpGnt` and `coreGnt` is high in any cycle. When both request, the snoop is granted unless the starvation limit has been reached.
- R11: After 4 consecutive snoop grants while the core is requesting, the core receives the next slot even if a snoop is still requesting.
- R12: Addresses are matched per 32-byte line. Address bits [4:2] select the 32-bit word within the line, and bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreReq | input | 1 | Core access request, held until granted |
| coreOp | input | 2 | 0 load, 1 store, 2 install |
| coreAddr | input | 32 | Core byte address |
| coreWdata | input | 32 | Store or install data |
| coreFillShared | input | 1 | Install marks the line shared |
| coreGnt | output | 1 | Core owns the array port this cycle |
| coreDone | output | 1 | Core result valid (cycle after grant) |
| coreHit | output | 1 | Core lookup hit |
| coreRdata | output | 32 | Core load data |
| snpReq | input | 1 | Snoop request, held until granted |
| snpOp | input | 2 | 0 read, 1 write, 2 invalidate |
| snpAddr | input | 32 | Snoop byte address |
| snpWdata | input | 32 | Snoop write data |
| snpGnt | output | 1 | Snoop owns the array port this cycle |
| snpDone | output | 1 | Snoop result valid (cycle after grant) |
| snpHit | output | 1 | Snoop lookup hit |
| snpRdata | output | 32 | Data returned for a snoop read |
| invValid | output | 1 | Invalidate broadcast strobe |
| invAddr | output | 32 | Broadcast line address, bits [4:0] zero |

## Verification
A snoop and a core access can compete for the same array cycle. The bench provokes this by raising both requests on the same clock edge. It checks that only the snoop is granted, that the core waits and is served on the next cycle, and that each done strobe follows its own grant. Under continuous snoop pressure with the core waiting, the bench records the grant sequence over several cycles and expects four snoop grants followed by one core grant. The checker also follows the consecutive-grant count and checks every cycle of that arbitration.

// File: rtl/snoopCohPkg.sv
package snoopCohPkg;

  typedef enum logic [1:0] {
    SNP_READ  = 2'd0,
    SNP_WRITE = 2'd1,
    SNP_INV   = 2'd2
  } snpOp_e;

  typedef enum logic [1:0] {
    CORE_LOAD  = 2'd0,
    CORE_STORE = 2'd1,
    CORE_FILL  = 2'd2
  } coreOp_e;

  // which requester owns the array port this cycle
  typedef struct packed {
    logic snpSlot;
    logic coreSlot;
  } slotSel_t;

  // array update strobes, qualified by the lookup result
  typedef struct packed {
    logic writeWord;
    logic install;
    logic installShared;
    logic setShared;
    logic clrShared;
    logic clrValid;
    logic broadcast;
  } arrayOps_t;

endpackage

// File: rtl/snoopCohCtrl.sv
module snoopCohCtrl
  import snoopCohPkg::*;
#(
  parameter int STARVE_LIMIT = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      snpReq,
  input  logic [1:0] snpOp,
  input  logic      coreReq,
  input  logic [1:0] coreOp,
  input  logic      coreFillShared,
  input  logic      hit,
  input  logic      lineShared,
  output slotSel_t  sel,
  output arrayOps_t ops
);

  localparam int CNT_W = $clog2(STARVE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STARVE_LIMIT);

  logic [CNT_W-1:0] snpRun;
  logic coreWins;

  assign coreWins     = coreReq && (!snpReq || (snpRun == LIMIT_V));
  assign sel.coreSlot = coreWins;
  assign sel.snpSlot  = snpReq && !coreWins;

  always_ff @(posedge clk) begin
    if (!rstN || !coreReq || coreWins) snpRun <= '0;
    else if (sel.snpSlot)              snpRun <= snpRun + 1'b1;
  end

  logic snpRd, snpWr, snpInv, coreSt, coreFill;
  assign snpRd    = sel.snpSlot  && (snpOp  == SNP_READ);
  assign snpWr    = sel.snpSlot  && (snpOp  == SNP_WRITE);
  assign snpInv   = sel.snpSlot  && (snpOp  == SNP_INV);
  assign coreSt   = sel.coreSlot && (coreOp == CORE_STORE);
  assign coreFill = sel.coreSlot && (coreOp == CORE_FILL);

  always_comb begin
    ops               = '0;
    ops.writeWord     = (hit && (snpWr || coreSt)) || coreFill;
    ops.install       = coreFill;
    ops.installShared = coreFillShared;
    ops.setShared     = snpRd && hit;
    ops.broadcast     = coreSt && hit && lineShared;
    ops.clrShared     = ops.broadcast;
    ops.clrValid      = snpInv && hit;
  end

endmodule

// File: rtl/snoopCohDatapath.sv
module snoopCohDatapath
  import snoopCohPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotSel_t          sel,
  input  arrayOps_t         ops,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpWdata,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  output logic              hit,
  output logic              lineShared,
  output logic              snpDone,
  output logic              snpHit,
  output logic [DATA_W-1:0] snpRdata,
  output logic              coreDone,
  output logic              coreHit,
  output logic [DATA_W-1:0] coreRdata,
  output logic              invValid,
  output logic [ADDR_W-1:0] invAddr
);

  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int WB_W    = $clog2(DATA_W / 8);
  localparam int WORDS   = LINE_BYTES / (DATA_W / 8);
  localparam int WSEL_W  = $clog2(WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;

  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES*WORDS];
  logic [LINES-1:0]  validArr;
  logic [LINES-1:0]  sharedArr;

  logic [ADDR_W-1:0] accAddr;
  logic [DATA_W-1:0] accWdata;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [IDX_W+WSEL_W-1:0] slot;
  logic [DATA_W-1:0] rdWord;
  logic unusedByteBits;

  assign accAddr  = sel.snpSlot ? snpAddr  : coreAddr;
  assign accWdata = sel.snpSlot ? snpWdata : coreWdata;
  assign idx      = accAddr[OFF_W +: IDX_W];
  assign tag      = accAddr[ADDR_W-1 -: TAG_W];
  assign slot     = {idx, accAddr[WB_W +: WSEL_W]};
  assign unusedByteBits = ^accAddr[WB_W-1:0];

  assign hit        = validArr[idx] && (tagArr[idx] == tag);
  assign lineShared = sharedArr[idx];
  assign rdWord     = dataArr[slot];

  // line state bits: reset clears every line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr  <= '0;
      sharedArr <= '0;
    end else begin
      if (ops.install) begin
        validArr[idx]  <= 1'b1;
        sharedArr[idx] <= ops.installShared;
      end
      if (ops.setShared) sharedArr[idx] <= 1'b1;
      if (ops.clrShared) sharedArr[idx] <= 1'b0;
      if (ops.clrValid) begin
        validArr[idx]  <= 1'b0;
        sharedArr[idx] <= 1'b0;
      end
    end
  end

  // tag and data storage, no reset needed
  always_ff @(posedge clk) begin
    if (ops.install)   tagArr[idx]   <= tag;
    if (ops.writeWord) dataArr[slot] <= accWdata;
  end

  // registered responses, one cycle after grant
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snpDone  <= 1'b0;
      snpHit   <= 1'b0;
      coreDone <= 1'b0;
      coreHit  <= 1'b0;
      invValid <= 1'b0;
      snpRdata <= '0;
      coreRdata <= '0;
      invAddr  <= '0;
    end else begin
      snpDone  <= sel.snpSlot;
      snpHit   <= sel.snpSlot && hit;
      coreDone <= sel.coreSlot;
      coreHit  <= sel.coreSlot && hit;
      invValid <= ops.broadcast;
      if (sel.snpSlot)  snpRdata  <= rdWord;
      if (sel.coreSlot) coreRdata <= rdWord;
      if (ops.broadcast) invAddr <= {accAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
  end

endmodule

// File: rtl/snoopCoherency.sv
module snoopCoherency
  import snoopCohPkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int LINES        = 8,
  parameter int LINE_BYTES   = 32,
  parameter int STARVE_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreReq,
  input  logic [1:0]        coreOp,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic              coreFillShared,
  output logic              coreGnt,
  output logic              coreDone,
  output logic              coreHit,
  output logic [DATA_W-1:0] coreRdata,
  input  logic              snpReq,
  input  logic [1:0]        snpOp,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpWdata,
  output logic              snpGnt,
  output logic              snpDone,
  output logic              snpHit,
  output logic [DATA_W-1:0] snpRdata,
  output logic              invValid,
  output logic [ADDR_W-1:0] invAddr
);

  slotSel_t  sel;
  arrayOps_t ops;
  logic      hit;
  logic      lineShared;

  snoopCohCtrl #(.STARVE_LIMIT(STARVE_LIMIT)) uCtrl (
    .clk(clk), .rstN(rstN),
    .snpReq(snpReq), .snpOp(snpOp),
    .coreReq(coreReq), .coreOp(coreOp), .coreFillShared(coreFillShared),
    .hit(hit), .lineShared(lineShared),
    .sel(sel), .ops(ops)
  );

  snoopCohDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES)
  ) uPath (
    .clk(clk), .rstN(rstN), .sel(sel), .ops(ops),
    .snpAddr(snpAddr), .snpWdata(snpWdata),
    .coreAddr(coreAddr), .coreWdata(coreWdata),
    .hit(hit), .lineShared(lineShared),
    .snpDone(snpDone), .snpHit(snpHit), .snpRdata(snpRdata),
    .coreDone(coreDone), .coreHit(coreHit), .coreRdata(coreRdata),
    .invValid(invValid), .invAddr(invAddr)
  );

  assign snpGnt  = sel.snpSlot;
  assign coreGnt = sel.coreSlot;

endmodule

// File: rtl/snoopCohChecker.sv
module snoopCohChecker #(
  parameter int STARVE_LIMIT = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       coreReq,
  input logic [1:0] coreOp,
  input logic       coreGnt,
  input logic       coreDone,
  input logic       coreHit,
  input logic       snpReq,
  input logic       snpGnt,
  input logic       snpDone,
  input logic       invValid,
  input logic [4:0] invLow
);

  localparam int CNT_W = $clog2(STARVE_LIMIT + 2);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STARVE_LIMIT);

  // independent count of snoop grants taken while the core waits
  logic [CNT_W-1:0] waitRun;
  always_ff @(posedge clk) begin
    if (!rstN || !coreReq || coreGnt) waitRun <= '0;
    else if (snpGnt)                  waitRun <= waitRun + 1'b1;
  end

  assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(snpGnt && coreGnt));

  assert_snoop_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    (snpReq && !(coreReq && waitRun == LIMIT_V)) |-> snpGnt);

  assert_core_not_starved_R11: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && waitRun == LIMIT_V) |-> coreGnt);

  assert_run_bounded_R11: assert property (@(posedge clk) disable iff (!rstN)
    waitRun <= LIMIT_V);

  assert_snoop_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    snpGnt |=> snpDone);

  assert_core_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    coreGnt |=> coreDone);

  assert_inv_from_store_R7: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (coreDone && coreHit && $past(coreOp) == 2'd1));

  assert_inv_line_aligned_R7: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (invLow == 5'd0));

  assert_miss_no_inv_R8: assert property (@(posedge clk) disable iff (!rstN)
    (coreDone && !coreHit) |-> !invValid);

endmodule

bind snoopCoherency snoopCohChecker #(.STARVE_LIMIT(STARVE_LIMIT)) uChk (
  .clk(clk), .rstN(rstN),
  .coreReq(coreReq), .coreOp(coreOp), .coreGnt(coreGnt),
  .coreDone(coreDone), .coreHit(coreHit),
  .snpReq(snpReq), .snpGnt(snpGnt), .snpDone(snpDone),
  .invValid(invValid), .invLow(invAddr[4:0])
);

// File: tb/tb_snoopCoherency.sv
module tb_snoopCoherency;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coreReq = 1'b0, coreFillShared = 1'b0;
  logic [1:0] coreOp = '0;
  logic [31:0] coreAddr = '0, coreWdata = '0;
  logic snpReq = 1'b0;
  logic [1:0] snpOp = '0;
  logic [31:0] snpAddr = '0, snpWdata = '0;
  logic coreGnt, coreDone, coreHit, snpGnt, snpDone, snpHit, invValid;
  logic [31:0] coreRdata, snpRdata, invAddr;

  always #10 clk = ~clk;

  snoopCoherency dut (
    .clk(clk), .rstN(rstN),
    .coreReq(coreReq), .coreOp(coreOp), .coreAddr(coreAddr),
    .coreWdata(coreWdata), .coreFillShared(coreFillShared),
    .coreGnt(coreGnt), .coreDone(coreDone), .coreHit(coreHit), .coreRdata(coreRdata),
    .snpReq(snpReq), .snpOp(snpOp), .snpAddr(snpAddr), .snpWdata(snpWdata),
    .snpGnt(snpGnt), .snpDone(snpDone), .snpHit(snpHit), .snpRdata(snpRdata),
    .invValid(invValid), .invAddr(invAddr)
  );

  int totalCnt = 0;
  int failCnt  = 0;

  task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  typedef struct packed {
    logic        isSnp;
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        sh;
    logic        expHit;
    logic        chkData;
    logic [31:0] expData;
    logic        expInv;
    logic [31:0] expInvAddr;
    logic [7:0]  req;
  } vec_t;

  // core ops: 0 load, 1 store, 2 install; snoop ops: 0 read, 1 write, 2 invalidate
  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd2, 32'h0000_0104, 32'h1111_1111, 1'b0, 1'b0, 1'b0, 32'h0,           1'b0, 32'h0,         8'd6},  // R6 install
    '{1'b0, 2'd0, 32'h0000_0104, 32'h0,         1'b0, 1'b1, 1'b1, 32'h1111_1111,   1'b0, 32'h0,         8'd8},  // R8 load hit
    '{1'b0, 2'd0, 32'h0000_0107, 32'h0,         1'b0, 1'b1, 1'b1, 32'h1111_1111,   1'b0, 32'h0,         8'd12}, // R12 byte bits ignored
    '{1'b1, 2'd0, 32'h0000_0104, 32'h0,         1'b0, 1'b1, 1'b1, 32'h1111_1111,   1'b0, 32'h0,         8'd2},  // R2 snoop read hit
    '{1'b0, 2'd1, 32'h0000_0108, 32'h2222_2222, 1'b0, 1'b1, 1'b0, 32'h0,           1'b1, 32'h0000_0100, 8'd5},  // R5 shared by snoop read
    '{1'b0, 2'd1, 32'h0000_0108, 32'h3333_3333, 1'b0, 1'b1, 1'b0, 32'h0,           1'b0, 32'h0,         8'd7},  // R7 shared cleared
    '{1'b1, 2'd1, 32'h0000_0104, 32'h4444_4444, 1'b0, 1'b1, 1'b0, 32'h0,           1'b0, 32'h0,         8'd3},  // R3 snoop write hit
    '{1'b0, 2'd0, 32'h0000_0104, 32'h0,         1'b0, 1'b1, 1'b1, 32'h4444_4444,   1'b0, 32'h0,         8'd3},  // R3 value seen
    '{1'b1, 2'd1, 32'h0000_1104, 32'h5555_5555, 1'b0, 1'b0, 1'b0, 32'h0,           1'b0, 32'h0,         8'd4},  // R4 write miss
    '{1'b0, 2'd0, 32'h0000_0104, 32'h0,         1'b0, 1'b1, 1'b1, 32'h4444_4444,   1'b0, 32'h0,         8'd4},  // R4 data kept
    '{1'b1, 2'd2, 32'h0000_2100, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,           1'b0, 32'h0,         8'd4},  // R4 invalidate miss
    '{1'b0, 2'd0, 32'h0000_0108, 32'h0,         1'b0, 1'b1, 1'b1, 32'h3333_3333,   1'b0, 32'h0,         8'd4},  // R4 line still valid
    '{1'b0, 2'd2, 32'h0000_0224, 32'h6666_6666, 1'b1, 1'b0, 1'b0, 32'h0,           1'b0, 32'h0,         8'd6},  // R6 shared install
    '{1'b0, 2'd1, 32'h0000_0224, 32'h7777_7777, 1'b0, 1'b1, 1'b0, 32'h0,           1'b1, 32'h0000_0220, 8'd6},  // R6 store broadcasts
    '{1'b0, 2'd1, 32'h0000_3224, 32'h9999_9999, 1'b0, 1'b0, 1'b0, 32'h0,           1'b0, 32'h0,         8'd8},  // R8 store miss
    '{1'b0, 2'd0, 32'h0000_0224, 32'h0,         1'b0, 1'b1, 1'b1, 32'h7777_7777,   1'b0, 32'h0,         8'd8},  // R8 miss wrote nothing
    '{1'b1, 2'd2, 32'h0000_023F, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0,           1'b0, 32'h0,         8'd9},  // R9 invalidate hit
    '{1'b0, 2'd0, 32'h0000_0224, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,           1'b0, 32'h0,         8'd9},  // R9 now misses
    '{1'b1, 2'd0, 32'h0000_0224, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,           1'b0, 32'h0,         8'd9},  // R9 snoop misses too
    '{1'b0, 2'd2, 32'h0040_0048, 32'h8888_8888, 1'b0, 1'b0, 1'b0, 32'h0,           1'b0, 32'h0,         8'd6},  // R6 private install
    '{1'b0, 2'd1, 32'h0040_0048, 32'hAAAA_AAAA, 1'b0, 1'b1, 1'b0, 32'h0,           1'b0, 32'h0,         8'd6}   // R6 no broadcast
  };

  task automatic runOp(input vec_t v, output logic done, output logic hitO,
                       output logic [31:0] data, output logic inv, output logic [31:0] invA);
    @(negedge clk);
    if (v.isSnp) begin
      snpReq = 1'b1; snpOp = v.op; snpAddr = v.addr; snpWdata = v.wdata;
    end else begin
      coreReq = 1'b1; coreOp = v.op; coreAddr = v.addr; coreWdata = v.wdata; coreFillShared = v.sh;
    end
    #1;
    while (!(v.isSnp ? snpGnt : coreGnt)) begin @(negedge clk); #1; end
    @(negedge clk);
    snpReq = 1'b0; coreReq = 1'b0;
    done = v.isSnp ? snpDone : coreDone;
    hitO = v.isSnp ? snpHit  : coreHit;
    data = v.isSnp ? snpRdata : coreRdata;
    inv  = invValid;
    invA = invAddr;
  endtask

  initial begin
    #(20 * 100000);
    failCnt++; totalCnt++;
    $display("FAIL watchdog expired: actual %0d expected 0", 1);
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    logic d, h, inv;
    logic [31:0] dat, invA;
    vec_t probe;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(!snpDone && !coreDone && !invValid, "R1 outputs low in reset",
          {29'b0, snpDone, coreDone, invValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!snpDone && !coreDone && !invValid, "R1 outputs low after release",
          {29'b0, snpDone, coreDone, invValid}, 32'h0);
    probe = '{1'b0, 2'd0, 32'h0000_0104, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 8'd1};
    runOp(probe, d, h, dat, inv, invA);
    check(d && !h, "R1 lookup misses after reset", {31'b0, h}, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      runOp(VECS[i], d, h, dat, inv, invA);
      check(d, $sformatf("R%0d vec %0d done", VECS[i].req, i), {31'b0, d}, 32'h1);
      check(h == VECS[i].expHit, $sformatf("R%0d vec %0d hit", VECS[i].req, i), {31'b0, h}, {31'b0, VECS[i].expHit});
      if (VECS[i].chkData)
        check(dat == VECS[i].expData, $sformatf("R%0d vec %0d data", VECS[i].req, i), dat, VECS[i].expData);
      check(inv == VECS[i].expInv, $sformatf("R%0d vec %0d broadcast", VECS[i].req, i), {31'b0, inv}, {31'b0, VECS[i].expInv});
      if (VECS[i].expInv)
        check(invA == VECS[i].expInvAddr, $sformatf("R%0d vec %0d broadcast addr", VECS[i].req, i), invA, VECS[i].expInvAddr);
      @(negedge clk);
      check(!invValid, $sformatf("R7 vec %0d broadcast is one cycle", i), {31'b0, invValid}, 32'h0);
    end

    // R10: same-cycle requests, snoop goes first
    @(negedge clk);
    coreReq = 1'b1; coreOp = 2'd0; coreAddr = 32'h0000_0104;
    snpReq  = 1'b1; snpOp  = 2'd0; snpAddr  = 32'h0000_0108;
    #1;
    check(snpGnt && !coreGnt, "R10 snoop wins tie", {30'b0, snpGnt, coreGnt}, 32'h2);
    @(negedge clk);
    snpReq = 1'b0;
    check(snpDone && !coreDone && snpHit && snpRdata == 32'h3333_3333, "R10 snoop served first",
          snpRdata, 32'h3333_3333);
    #1;
    check(coreGnt && !snpGnt, "R10 core served next", {30'b0, snpGnt, coreGnt}, 32'h1);
    @(negedge clk);
    coreReq = 1'b0;
    check(coreDone && coreHit && coreRdata == 32'h4444_4444, "R10 core result", coreRdata, 32'h4444_4444);

    // R11: sustained snoop pressure
    @(negedge clk);
    coreReq = 1'b1; coreOp = 2'd0; coreAddr = 32'h0000_0104;
    snpReq  = 1'b1; snpOp  = 2'd0; snpAddr  = 32'h0000_0108;
    for (int c = 0; c < 5; c++) begin
      #1;
      if (c < 4)
        check(snpGnt && !coreGnt, $sformatf("R11 cycle %0d snoop", c), {30'b0, snpGnt, coreGnt}, 32'h2);
      else
        check(coreGnt && !snpGnt, "R11 core gets slot after 4 snoops", {30'b0, snpGnt, coreGnt}, 32'h1);
      @(negedge clk);
    end
    coreReq = 1'b0;
    #1;
    check(snpGnt, "R11 snoop resumes", {31'b0, snpGnt}, 32'h1);
    @(negedge clk);
    snpReq = 1'b0;

    // R1: a second reset drops all lines
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    probe = '{1'b1, 2'd0, 32'h0000_0108, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 8'd1};
    runOp(probe, d, h, dat, inv, invA);
    check(d && !h, "R1 line invalid after reset", {31'b0, h}, 32'h0);

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule